// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block holds the time of day and the calendar date as packed BCD fields: seconds, minutes, hours, day of month, weekday, month with a century flag, and a two-digit year. It counts upward once per second. The second is formed inside the block by dividing an incoming tick strobe by a parameterised ratio. The strobe comes from an oscillator and prescaler that sit outside the block. All carries are resolved in a single cycle. This covers the month lengths and the leap-year case for years 00 to 99.

A host reaches the fields through a byte-wide register port. Writes arrive as beats qualified by `wr_valid_i`. A beat with `wr_start_i` high uses `wr_addr_i`. A beat with `wr_start_i` low goes to the register after the one written last, so the whole time and date can be loaded as one run of seven beats. The write port carries no ready signal. Every valid beat is taken in the cycle it is presented, and the host is never held off. Reads are combinational from `rd_addr_i`. A halt control freezes the counters so that a new time can be loaded without tearing. A sticky validity flag tells software whether the time has been set since reset.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the registers read as follows: control 0x00, seconds 0x80 (validity flag set, zero seconds), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01 with the century flag clear, and year 0x00.
- R2: The registers sit at these indices: control 0, reserved 1, seconds 2, minutes 3, hours 4, day 5, weekday 6, month 7, year 8. Writes keep only the valid bits of each register: 7 bits for seconds and minutes, 6 for hours and day, 3 for weekday, and 5 for month plus bit 7 (century). The year keeps all 8 bits. Unused bits read as zero. Index 1 and indices 9 to 15 read as zero, and writes to them change nothing.
- R3: Bit 5 of the control register is the halt bit. While it reads 1, no field advances and the tick divider is held at zero. Writing 0 resumes counting.
- R4: Bit 7 of the seconds register is the validity flag. Reset sets it. Counting never changes it. Only a write to the seconds register changes it, and that write loads it from bit 7 of the written byte.
- R5: Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours. Hours roll from 23 to 00 and carry into the day. A field at or above its last value rolls.
- R6: The day rolls to 01 after the last day of the month. The last day is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. For month 2 it is 29 when the year is divisible by 4, otherwise 28.
- R7: Each day rollover advances the weekday by one, and weekday 6 is followed by 0.
- R8: The month rolls from 12 to 01 and carries into the year. The year rolls from 99 to 00 and toggles the century flag.
- R9: A write beat with `wr_start_i` low is applied to the index one above the previous beat's index, wrapping from 15 to 0.
- R10: If a write beat hits a register at index 2 to 8 in the same cycle that a second completes, that second's advance is dropped and the written value stands.
- R11: While running, the fields advance once for every `TICK_DIV` tick strobes. The first advance after the halt bit is cleared comes on the `TICK_DIV`-th strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Tick strobe from the external prescaler, one cycle per tick |
| wr_valid_i | input | 1 | Write beat present, always accepted |
| wr_start_i | input | 1 | Beat takes its index from `wr_addr_i`; otherwise the index follows on from the previous beat |
| wr_addr_i | input | 4 | Register index for a starting beat |
| wr_data_i | input | 8 | Write byte |
| rd_addr_i | input | 4 | Read register index |
| rd_data_o | output | 8 | Combinational read data |

## Verification
The assertions check the following on every cycle: that the fields stay frozen while halted, that the validity flag is held until a seconds write, that seconds wrap at 59, that the weekday wraps on a day carry, that the century flips on a year wrap, and that the write index follows on after each beat. Some behaviour shows only in the bench's scenarios: the month-length and leap-year decisions across February, April and December, the exact number of strobes before the first advance after release, and a write colliding with a completed second. These are checked against a behavioural reference model and against hand-computed register values.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int REG_AW = 4;
  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t IDX_CTRL  = 4'h0;
  localparam reg_addr_t IDX_RSVD  = 4'h1;
  localparam reg_addr_t IDX_SEC   = 4'h2;
  localparam reg_addr_t IDX_MIN   = 4'h3;
  localparam reg_addr_t IDX_HOUR  = 4'h4;
  localparam reg_addr_t IDX_DAY   = 4'h5;
  localparam reg_addr_t IDX_WDAY  = 4'h6;
  localparam reg_addr_t IDX_MON   = 4'h7;
  localparam reg_addr_t IDX_YEAR  = 4'h8;

  localparam int HALT_BIT = 5;
  localparam int FLAG_BIT = 7;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
  } tod_t;

  typedef struct packed {
    logic [5:0] day;
    logic [2:0] wday;
    logic [4:0] mon;
    logic       cent;
    logic [7:0] year;
  } date_t;

  // one BCD step: ones digit 9 (or beyond) carries into tens
  function automatic logic [7:0] bcd_up(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10*t + u is divisible by 4 exactly when 2*t + u is
  function automatic logic year_is_leap(input logic [7:0] y);
    logic [5:0] s;
    s = {1'b0, y[7:4], 1'b0} + {2'b00, y[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [5:0] month_last_day(input logic [4:0] mon,
                                                input logic [7:0] year);
    case (mon)
      5'h02:                      return year_is_leap(year) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int DIV = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic halt_i,
  output logic sec_pulse_o
);

  generate
    if (DIV <= 1) begin : g_pass
      assign sec_pulse_o = tick_i & ~halt_i;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);

      logic [CW-1:0] cnt_q;
      logic          at_last;

      assign at_last = (cnt_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (halt_i) cnt_q <= '0;
        else if (tick_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      end

      assign sec_pulse_o = tick_i & ~halt_i & at_last;
    end
  endgenerate

endmodule

// File: rtl/rtc_clock_next.sv
module rtc_clock_next
  import rtc_cal_pkg::*;
(
  input  tod_t cur_i,
  output tod_t nxt_o,
  output logic day_carry_o
);

  logic sec_w, min_w, hour_w;

  assign sec_w  = (cur_i.sec  >= 7'h59);
  assign min_w  = (cur_i.min  >= 7'h59);
  assign hour_w = (cur_i.hour >= 6'h23);

  always_comb begin
    nxt_o = cur_i;
    nxt_o.sec = sec_w ? 7'h00 : 7'(bcd_up({1'b0, cur_i.sec}));
    if (sec_w) begin
      nxt_o.min = min_w ? 7'h00 : 7'(bcd_up({1'b0, cur_i.min}));
      if (min_w)
        nxt_o.hour = hour_w ? 6'h00 : 6'(bcd_up({2'b00, cur_i.hour}));
    end
  end

  assign day_carry_o = sec_w & min_w & hour_w;

endmodule

// File: rtl/rtc_date_next.sv
module rtc_date_next
  import rtc_cal_pkg::*;
(
  input  date_t cur_i,
  input  logic  carry_i,
  output date_t nxt_o,
  output logic  yr_wrap_o
);

  logic [5:0] last_day;
  logic       day_w, mon_w, yr_w;

  assign last_day = month_last_day(cur_i.mon, cur_i.year);
  assign day_w    = (cur_i.day  >= last_day);
  assign mon_w    = (cur_i.mon  >= 5'h12);
  assign yr_w     = (cur_i.year >= 8'h99);

  always_comb begin
    nxt_o = cur_i;
    if (carry_i) begin
      nxt_o.day  = day_w ? 6'h01 : 6'(bcd_up({2'b00, cur_i.day}));
      nxt_o.wday = (cur_i.wday >= 3'd6) ? 3'd0 : cur_i.wday + 3'd1;
      if (day_w) begin
        nxt_o.mon = mon_w ? 5'h01 : 5'(bcd_up({3'b000, cur_i.mon}));
        if (mon_w) begin
          nxt_o.year = yr_w ? 8'h00 : bcd_up(cur_i.year);
          if (yr_w) nxt_o.cent = ~cur_i.cent;
        end
      end
    end
  end

  assign yr_wrap_o = carry_i & day_w & mon_w & yr_w;

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int TICK_DIV = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_valid_i,
  input  logic       wr_start_i,
  input  logic [3:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [3:0] rd_addr_i,
  output logic [7:0] rd_data_o
);

  localparam tod_t  TOD_RST  = '{sec: 7'h00, min: 7'h00, hour: 6'h00};
  localparam date_t DATE_RST = '{day: 6'h01, wday: 3'd0, mon: 5'h01,
                                 cent: 1'b0, year: 8'h00};

  logic      halt_q, vl_q;
  tod_t      tod_q, tod_n;
  date_t     date_q, date_n;
  reg_addr_t ptr_q, waddr;
  logic      sec_pulse, day_carry, yr_wrap, wr_time, adv;

  rtc_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .halt_i      (halt_q),
    .sec_pulse_o (sec_pulse)
  );

  rtc_clock_next u_tod (
    .cur_i       (tod_q),
    .nxt_o       (tod_n),
    .day_carry_o (day_carry)
  );

  rtc_date_next u_date (
    .cur_i     (date_q),
    .carry_i   (day_carry),
    .nxt_o     (date_n),
    .yr_wrap_o (yr_wrap)
  );

  assign waddr   = wr_start_i ? wr_addr_i : ptr_q;
  assign wr_time = wr_valid_i && (waddr >= IDX_SEC) && (waddr <= IDX_YEAR);
  assign adv     = sec_pulse && !wr_time;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      vl_q   <= 1'b1;
      tod_q  <= TOD_RST;
      date_q <= DATE_RST;
      ptr_q  <= '0;
    end else begin
      if (adv) begin
        tod_q  <= tod_n;
        date_q <= date_n;
      end
      if (wr_valid_i) begin
        ptr_q <= waddr + 1'b1;
        case (waddr)
          IDX_CTRL: halt_q <= wr_data_i[HALT_BIT];
          IDX_SEC: begin
            vl_q      <= wr_data_i[FLAG_BIT];
            tod_q.sec <= wr_data_i[6:0];
          end
          IDX_MIN:  tod_q.min   <= wr_data_i[6:0];
          IDX_HOUR: tod_q.hour  <= wr_data_i[5:0];
          IDX_DAY:  date_q.day  <= wr_data_i[5:0];
          IDX_WDAY: date_q.wday <= wr_data_i[2:0];
          IDX_MON: begin
            date_q.cent <= wr_data_i[7];
            date_q.mon  <= wr_data_i[4:0];
          end
          IDX_YEAR: date_q.year <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      IDX_CTRL: rd_data_o[HALT_BIT] = halt_q;
      IDX_SEC:  rd_data_o = {vl_q, tod_q.sec};
      IDX_MIN:  rd_data_o = {1'b0, tod_q.min};
      IDX_HOUR: rd_data_o = {2'b00, tod_q.hour};
      IDX_DAY:  rd_data_o = {2'b00, date_q.day};
      IDX_WDAY: rd_data_o = {5'b00000, date_q.wday};
      IDX_MON:  rd_data_o = {date_q.cent, 2'b00, date_q.mon};
      IDX_YEAR: rd_data_o = date_q.year;
      default:  rd_data_o = '0;
    endcase
  end

  assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_valid_i) |=> ($stable(tod_q) && $stable(date_q)));

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_q && !(wr_valid_i && waddr == IDX_SEC)) |=> vl_q);

  assert_sec_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && tod_q.sec == 7'h59) |=> (tod_q.sec == 7'h00));

  assert_wday_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && day_carry && date_q.wday == 3'd6) |=> (date_q.wday == 3'd0));

  assert_century_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && yr_wrap) |=> (date_q.cent != $past(date_q.cent)));

  assert_index_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_i |=> (ptr_q == reg_addr_t'($past(waddr) + 1'b1)));

endmodule

// File: tb/sim_rtc_bcd_calendar.sv
module sim_rtc_bcd_calendar;

  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_start = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  int peek_addr = -1;
  bit done = 0;

  // reference model state, fields kept as raw BCD values
  int m_stop, m_vl, m_sec, m_min, m_hour, m_day, m_wday, m_mon, m_cent, m_year;
  int m_pc, m_ptr;

  rtc_bcd_calendar #(.TICK_DIV(DIV)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .wr_valid_i (wr_valid),
    .wr_start_i (wr_start),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int b2i(int raw);
    return ((raw >> 4) * 10) + (raw & 15);
  endfunction

  function automatic int i2b(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int days_of(int mon, int year);
    if (mon == 2) return (year % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic int model_read(int a);
    case (a)
      0: return m_stop ? 32 : 0;
      2: return (m_vl << 7) | m_sec;
      3: return m_min;
      4: return m_hour;
      5: return m_day;
      6: return m_wday;
      7: return (m_cent << 7) | m_mon;
      8: return m_year;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int a);
    case (a)
      0: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      6: return "R7";
      7, 8: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic model_advance();
    int v;
    v = b2i(m_sec);
    if (v < 59) begin m_sec = i2b(v + 1); return; end
    m_sec = 0;
    v = b2i(m_min);
    if (v < 59) begin m_min = i2b(v + 1); return; end
    m_min = 0;
    v = b2i(m_hour);
    if (v < 23) begin m_hour = i2b(v + 1); return; end
    m_hour = 0;
    m_wday = (m_wday >= 6) ? 0 : m_wday + 1;
    v = b2i(m_day);
    if (v < days_of(b2i(m_mon), b2i(m_year))) begin m_day = i2b(v + 1); return; end
    m_day = 1;
    v = b2i(m_mon);
    if (v < 12) begin m_mon = i2b(v + 1); return; end
    m_mon = 1;
    v = b2i(m_year);
    if (v < 99) begin m_year = i2b(v + 1); return; end
    m_year = 0;
    m_cent = 1 - m_cent;
  endtask

  always @(posedge clk) begin
    int a;
    bit pulse, wt;
    if (!rst_n) begin
      m_stop = 0; m_vl = 1; m_sec = 0; m_min = 0; m_hour = 0;
      m_day = 1; m_wday = 0; m_mon = 1; m_cent = 0; m_year = 0;
      m_pc = 0; m_ptr = 0;
    end else begin
      pulse = 0;
      wt = 0;
      a = 0;
      if (m_stop != 0) m_pc = 0;
      else if (tick) begin
        if (m_pc == DIV - 1) begin m_pc = 0; pulse = 1; end
        else m_pc = m_pc + 1;
      end
      if (wr_valid) begin
        a = wr_start ? int'(wr_addr) : m_ptr;
        m_ptr = (a + 1) % 16;
        wt = (a >= 2 && a <= 8);
      end
      if (pulse && !wt) model_advance();
      if (wr_valid) begin
        case (a)
          0: m_stop = (wr_data >> 5) & 1;
          2: begin m_vl = wr_data[7]; m_sec = wr_data & 8'h7F; end
          3: m_min = wr_data & 8'h7F;
          4: m_hour = wr_data & 8'h3F;
          5: m_day = wr_data & 8'h3F;
          6: m_wday = wr_data & 8'h07;
          7: begin m_cent = wr_data[7]; m_mon = wr_data & 8'h1F; end
          8: m_year = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, index walks round the map
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({"model ", req_of(int'(rd_addr))}, rd_data, 8'(model_read(int'(rd_addr))));
      rd_addr = (peek_addr >= 0) ? 4'(peek_addr) : rd_addr + 4'd1;
    end
  end

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    wr_valid = 0; wr_start = 0; tick = 0;
  endtask

  task automatic wr1(int a, logic [7:0] d);
    cyc();
    wr_valid = 1; wr_start = 1; wr_addr = 4'(a); wr_data = d;
    cyc();
    idle();
  endtask

  task automatic burst7(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                        logic [7:0] d, logic [7:0] w, logic [7:0] mo,
                        logic [7:0] y);
    logic [7:0] b [7];
    b[0] = s; b[1] = mi; b[2] = h; b[3] = d; b[4] = w; b[5] = mo; b[6] = y;
    for (int i = 0; i < 7; i++) begin
      cyc();
      wr_valid = 1; wr_start = (i == 0); wr_addr = 4'h2; wr_data = b[i];
    end
    cyc();
    idle();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      cyc();
      tick = 1;
    end
    cyc();
    tick = 0;
  endtask

  task automatic peek(string tag, int a, logic [7:0] exp);
    peek_addr = a;
    @(negedge clk);
    #1;
    check(tag, rd_data, exp);
    peek_addr = -1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: got=hung exp=finished");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;

    // R1 reset values
    peek("R1 ctrl", 0, 8'h00);
    peek("R1 sec", 2, 8'h80);
    peek("R1 day", 5, 8'h01);
    peek("R1 month", 7, 8'h01);
    peek("R1 year", 8, 8'h00);

    // R4 flag survives counting; R11 eight strobes give two seconds
    run(8);
    peek("R4 flag kept while counting", 2, 8'h82);

    // R2 masking and reserved indices
    wr1(0, 8'hFF);
    peek("R2 ctrl keeps only halt", 0, 8'h20);
    wr1(3, 8'hFF);
    peek("R2 minutes 7 bits", 3, 8'h7F);
    wr1(4, 8'hFF);
    peek("R2 hours 6 bits", 4, 8'h3F);
    wr1(6, 8'hFF);
    peek("R2 weekday 3 bits", 6, 8'h07);
    wr1(1, 8'hFF);
    peek("R2 reserved reads zero", 1, 8'h00);
    wr1(12, 8'h55);
    peek("R2 unmapped reads zero", 12, 8'h00);

    // R9 R6 R7 R5: end of February in a common year
    wr1(0, 8'h20);
    burst7(8'h50, 8'h59, 8'h23, 8'h28, 8'h06, 8'h02, 8'h23);
    peek("R9 burst sec", 2, 8'h50);
    peek("R9 burst year", 8, 8'h23);
    wr1(0, 8'h00);
    run(40);
    peek("R5 sec wrap", 2, 8'h00);
    peek("R5 hour wrap", 4, 8'h00);
    peek("R6 feb common", 5, 8'h01);
    peek("R6 march", 7, 8'h03);
    peek("R7 weekday 6 to 0", 6, 8'h00);

    // R6 leap February
    wr1(0, 8'h20);
    burst7(8'h50, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h24);
    wr1(0, 8'h00);
    run(40);
    peek("R6 leap day", 5, 8'h29);
    peek("R6 leap month", 7, 8'h02);
    peek("R7 weekday step", 6, 8'h03);

    // R6 thirty-day month
    wr1(0, 8'h20);
    burst7(8'h50, 8'h59, 8'h23, 8'h30, 8'h01, 8'h04, 8'h25);
    wr1(0, 8'h00);
    run(40);
    peek("R6 april end", 5, 8'h01);
    peek("R6 may", 7, 8'h05);

    // R8 year and century wrap
    wr1(0, 8'h20);
    burst7(8'h50, 8'h59, 8'h23, 8'h31, 8'h03, 8'h12, 8'h99);
    wr1(0, 8'h00);
    run(40);
    peek("R8 year wrap", 8, 8'h00);
    peek("R8 century set, january", 7, 8'h81);
    peek("R8 day", 5, 8'h01);

    // R3 halt freezes
    wr1(0, 8'h20);
    burst7(8'h10, 8'h00, 8'h12, 8'h15, 8'h02, 8'h06, 8'h30);
    run(20);
    peek("R3 frozen sec", 2, 8'h10);
    peek("R3 frozen hour", 4, 8'h12);

    // R11 first advance after release on the DIV-th strobe
    wr1(0, 8'h00);
    run(DIV - 1);
    peek("R11 not yet", 2, 8'h10);
    run(1);
    peek("R11 first advance", 2, 8'h11);

    // R10 write collides with a completed second
    run(DIV - 1);
    cyc();
    tick = 1; wr_valid = 1; wr_start = 1; wr_addr = 4'h3; wr_data = 8'h05;
    cyc();
    idle();
    peek("R10 advance dropped", 2, 8'h11);
    peek("R10 write stands", 3, 8'h05);

    // R4 cleared by seconds write with bit 7 low (already), set by bit 7 high
    wr1(2, 8'hA4);
    peek("R4 flag loaded from bit 7", 2, 8'hA4);

    repeat (4) cyc();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule